// File: doc/BRIEF.md
# Serial Bus Control Register Bank

This block is a bank of 32-bit control registers for a serial bus node. Each register sits at a quadlet-aligned byte offset. A request port takes single-quadlet reads and writes and gives back, one cycle later, a 2-bit response code and the read data. The bank holds a node-identity register whose bus field can be written, a split-transaction timeout split over a high word (seconds) and a low word (fractions of a second), a cycle-time register, a bus-time register and a broadcast-channel register. Each register has its own write mask.

The timeout pair is also presented on a separate output as one count in 1/8192-second units, for an external timer. The cycle counter lives outside the block. A read of cycle time or bus time samples that counter. If the new sample is smaller than the stored one, the counter has wrapped, and bus time moves forward by one step of 128 before the read data is formed. A bus-time read merges the stored seconds count with the top seven bits of the fresh cycle sample.

Top module: `sbus_ctrl_regs`

## Requirements
- R1: Every request gets `rsp_valid_o` high in the following cycle only. The code is 2'b00 for complete, 2'b01 for type error and 2'b10 for address error. `rsp_rdata_o` is zero unless the response is a completed read.
- R2: A request whose address has bits [1:0] nonzero, or whose byte length is not exactly 4, gets a type error and changes no register.
- R3: The map uses these byte offsets: 0x00 state, 0x04 node IDs, 0x08 reset-start, 0x0C timeout high, 0x10 timeout low, 0x14 cycle time, 0x18 bus time, 0x20 broadcast channel. Offset 0x1C (busy timeout) and every other aligned offset give an address error.
- R4: The state register reads 0, and writes to it complete with no effect. A write to reset-start completes with no effect. A read of reset-start gets a type error.
- R5: After reset, timeout high is 0 and timeout low is 800 << 19. A write to high keeps only bits [2:0]. A write to low keeps only bits [31:19]. Both read back as stored.
- R6: `split_units_o` equals (high[2:0] << 13) + (low >> 19) at all times. It is 800 after reset and follows a write one cycle later.
- R7: A cycle-time read stores the `cyc_cnt_i` value and returns it. A cycle-time write loads the register with the written word.
- R8: On a cycle-time or bus-time read, if `cyc_cnt_i` is below the stored cycle time, bus time increases by 128 (modulo 2^32) before the read data is formed. Otherwise bus time is unchanged.
- R9: A bus-time write keeps only bits [31:7]. A bus-time read returns the bus time OR (`cyc_cnt_i` >> 25).
- R10: Node IDs read as {bus[9:0] at bits 31:22, `node_num_i` at bits 21:16, zero below}. The bus field resets to 0x3FF. A write replaces only the bus field, with bits [31:22] of the written word.
- R11: The broadcast-channel register resets to 0x8000001F. Only bit 30 is writable. All other bits keep their reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per access |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset in the bank |
| req_len_i | input | LEN_W | Byte length of the access |
| req_wdata_i | input | 32 | Write data |
| cyc_cnt_i | input | 32 | Free-running cycle counter value |
| node_num_i | input | 6 | Node number on the bus |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 2 | Response code |
| rsp_rdata_o | output | 32 | Read data |
| split_units_o | output | 16 | Split timeout in 1/8192 s |

## Verification
A wrong cycle-time copy shows up as a missed or spurious wrap. The error is visible in the very next bus-time read as a value off by 128, and it persists in every later bus-time read. A corrupted timeout register appears on `split_units_o` in the cycle after the bad write, without any read. Write-mask or decode faults appear in the response that follows the request, either as wrong read-back bits or as a wrong response code.

// File: rtl/sbus_regs_pkg.sv
package sbus_regs_pkg;
  typedef enum logic [1:0] {
    RSP_OK   = 2'b00,
    RSP_TYPE = 2'b01,
    RSP_ADDR = 2'b10
  } rsp_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STATE, SEL_NODE, SEL_RST, SEL_SPL_HI,
    SEL_SPL_LO, SEL_CYC, SEL_BUS, SEL_BCAST
  } sel_e;

  localparam int unsigned OFF_STATE  = 'h00;
  localparam int unsigned OFF_NODE   = 'h04;
  localparam int unsigned OFF_RST    = 'h08;
  localparam int unsigned OFF_SPL_HI = 'h0C;
  localparam int unsigned OFF_SPL_LO = 'h10;
  localparam int unsigned OFF_CYC    = 'h14;
  localparam int unsigned OFF_BUS    = 'h18;
  localparam int unsigned OFF_BCAST  = 'h20;
endpackage

// File: rtl/sbus_regs_decode.sv
module sbus_regs_decode
  import sbus_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output sel_e              sel_o,
  output rsp_e              code_o
);
  localparam logic [LEN_W-1:0] QUAD_LEN = LEN_W'(4);

  always_comb begin
    sel_o  = SEL_NONE;
    code_o = RSP_OK;
    if (addr_i[1:0] != 2'b00 || len_i != QUAD_LEN) begin
      code_o = RSP_TYPE;
    end else begin
      case (addr_i)
        ADDR_W'(OFF_STATE):  sel_o = SEL_STATE;
        ADDR_W'(OFF_NODE):   sel_o = SEL_NODE;
        ADDR_W'(OFF_RST): begin
          if (we_i) sel_o = SEL_RST;
          else      code_o = RSP_TYPE;
        end
        ADDR_W'(OFF_SPL_HI): sel_o = SEL_SPL_HI;
        ADDR_W'(OFF_SPL_LO): sel_o = SEL_SPL_LO;
        ADDR_W'(OFF_CYC):    sel_o = SEL_CYC;
        ADDR_W'(OFF_BUS):    sel_o = SEL_BUS;
        ADDR_W'(OFF_BCAST):  sel_o = SEL_BCAST;
        default:             code_o = RSP_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/sbus_regs_split.sv
module sbus_regs_split #(
  parameter int HI_BITS   = 3,
  parameter int FRAC_BITS = 13,
  parameter int LO_RST    = 800
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_hi_i,
  input  logic                         wr_lo_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  hi_o,
  output logic [31:0]                  lo_o,
  output logic [HI_BITS+FRAC_BITS-1:0] units_o
);
  localparam int          LO_SHIFT = 32 - FRAC_BITS;
  localparam int          UNITS_W  = HI_BITS + FRAC_BITS;
  localparam logic [31:0] HI_MASK  = 32'((64'd1 << HI_BITS) - 64'd1);
  localparam logic [31:0] LO_MASK  = ~32'((64'd1 << LO_SHIFT) - 64'd1);

  logic [31:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= 32'(LO_RST) << LO_SHIFT;
    end else begin
      if (wr_hi_i) hi_q <= wdata_i & HI_MASK;
      if (wr_lo_i) lo_q <= wdata_i & LO_MASK;
    end
  end

  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  // fields do not overlap, so the sum is a concatenation
  assign units_o = {hi_q[HI_BITS-1:0], lo_q[31:LO_SHIFT]};

  // R5
  hi_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_q & ~HI_MASK) == 32'd0);
  // R5
  lo_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_q & ~LO_MASK) == 32'd0);
  // R6
  units_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> units_o[UNITS_W-1:FRAC_BITS] == $past(wdata_i[HI_BITS-1:0]));
endmodule

// File: rtl/sbus_regs_time.sv
module sbus_regs_time #(
  parameter int BUS_LSB = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sample_i,
  input  logic        wr_cyc_i,
  input  logic        wr_bus_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] cyc_cnt_i,
  output logic [31:0] cyc_rd_o,
  output logic [31:0] bus_rd_o
);
  localparam logic [31:0] STEP     = 32'(64'd1 << BUS_LSB);
  localparam logic [31:0] BUS_MASK = ~(STEP - 32'd1);
  localparam int          CYC_SH   = 32 - BUS_LSB;

  logic [31:0] cyc_q, bus_q, bus_adv;
  logic        wrap;

  assign wrap     = sample_i && (cyc_cnt_i < cyc_q);
  assign bus_adv  = wrap ? bus_q + STEP : bus_q;
  assign cyc_rd_o = cyc_cnt_i;
  assign bus_rd_o = bus_adv | (cyc_cnt_i >> CYC_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      bus_q <= '0;
    end else begin
      if (sample_i) begin
        cyc_q <= cyc_cnt_i;
        bus_q <= bus_adv;
      end
      if (wr_cyc_i) cyc_q <= wdata_i;
      if (wr_bus_i) bus_q <= wdata_i & BUS_MASK;
    end
  end

  // R8
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && cyc_cnt_i < cyc_q) |=> bus_q == $past(bus_q) + STEP);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && cyc_cnt_i >= cyc_q) |=> $stable(bus_q));
  // R9
  bus_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_q & ~BUS_MASK) == 32'd0);
  // R7
  cyc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> cyc_q == $past(cyc_cnt_i));
endmodule

// File: rtl/sbus_ctrl_regs.sv
module sbus_ctrl_regs
  import sbus_regs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 4,
  parameter int NODE_W     = 6,
  parameter int BUSF_W     = 10,
  parameter int SPL_HI_W   = 3,
  parameter int SPL_FRAC_W = 13,
  parameter int SPL_LO_RST = 800,
  parameter int BUS_LSB    = 7,
  parameter int BCAST_CH   = 31
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           req_we_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [LEN_W-1:0]               req_len_i,
  input  logic [31:0]                    req_wdata_i,
  input  logic [31:0]                    cyc_cnt_i,
  input  logic [NODE_W-1:0]              node_num_i,
  output logic                           rsp_valid_o,
  output logic [1:0]                     rsp_code_o,
  output logic [31:0]                    rsp_rdata_o,
  output logic [SPL_HI_W+SPL_FRAC_W-1:0] split_units_o
);
  localparam int          LOW_W     = 32 - BUSF_W - NODE_W;
  localparam logic [31:0] BCAST_RST = 32'h8000_0000 | 32'(BCAST_CH);
  localparam int          VALID_BIT = 30;

  sel_e        sel;
  rsp_e        code;
  logic        acc_ok, wr_ok, rd_ok;
  logic [31:0] spl_hi, spl_lo, cyc_rd, bus_rd, rd_mux;
  logic [BUSF_W-1:0] node_bus_q;
  logic        bcast_valid_q;
  logic        rsp_valid_q;
  rsp_e        rsp_code_q;
  logic [31:0] rsp_rdata_q;
  sel_e        rsp_sel_q;
  logic        rsp_we_q;

  sbus_regs_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .we_i   (req_we_i),
    .addr_i (req_addr_i),
    .len_i  (req_len_i),
    .sel_o  (sel),
    .code_o (code)
  );

  assign acc_ok = req_i && (code == RSP_OK);
  assign wr_ok  = acc_ok && req_we_i;
  assign rd_ok  = acc_ok && !req_we_i;

  sbus_regs_split #(.HI_BITS(SPL_HI_W), .FRAC_BITS(SPL_FRAC_W), .LO_RST(SPL_LO_RST)) u_split (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hi_i (wr_ok && sel == SEL_SPL_HI),
    .wr_lo_i (wr_ok && sel == SEL_SPL_LO),
    .wdata_i (req_wdata_i),
    .hi_o    (spl_hi),
    .lo_o    (spl_lo),
    .units_o (split_units_o)
  );

  sbus_regs_time #(.BUS_LSB(BUS_LSB)) u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (rd_ok && (sel == SEL_CYC || sel == SEL_BUS)),
    .wr_cyc_i  (wr_ok && sel == SEL_CYC),
    .wr_bus_i  (wr_ok && sel == SEL_BUS),
    .wdata_i   (req_wdata_i),
    .cyc_cnt_i (cyc_cnt_i),
    .cyc_rd_o  (cyc_rd),
    .bus_rd_o  (bus_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      node_bus_q    <= '1;
      bcast_valid_q <= 1'b0;
    end else begin
      if (wr_ok && sel == SEL_NODE)  node_bus_q    <= req_wdata_i[31 -: BUSF_W];
      if (wr_ok && sel == SEL_BCAST) bcast_valid_q <= req_wdata_i[VALID_BIT];
    end
  end

  always_comb begin
    case (sel)
      SEL_NODE:   rd_mux = {node_bus_q, node_num_i, {LOW_W{1'b0}}};
      SEL_SPL_HI: rd_mux = spl_hi;
      SEL_SPL_LO: rd_mux = spl_lo;
      SEL_CYC:    rd_mux = cyc_rd;
      SEL_BUS:    rd_mux = bus_rd;
      SEL_BCAST: begin
        rd_mux            = BCAST_RST;
        rd_mux[VALID_BIT] = bcast_valid_q;
      end
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RSP_OK;
      rsp_rdata_q <= '0;
      rsp_sel_q   <= SEL_NONE;
      rsp_we_q    <= 1'b0;
    end else begin
      rsp_valid_q <= req_i;
      rsp_code_q  <= req_i ? code : RSP_OK;
      rsp_rdata_q <= rd_ok ? rd_mux : '0;
      rsp_sel_q   <= req_i ? sel : SEL_NONE;
      rsp_we_q    <= req_we_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_code_o  = rsp_code_q;
  assign rsp_rdata_o = rsp_rdata_q;

  // R1
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R1
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && rsp_rdata_o == 32'd0);
  // R2
  misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_addr_i[1:0] != 2'b00) |=> rsp_code_o == RSP_TYPE);
  // R11
  bcast_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_sel_q == SEL_BCAST && !rsp_we_q)
      |-> (rsp_rdata_o & ~(32'd1 << VALID_BIT)) == BCAST_RST);
endmodule

// File: tb/sim_sbus_ctrl_regs.sv
module sim_sbus_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  len = '0;
  logic [31:0] wdata = '0, cyc_cnt = '0;
  logic [5:0]  node_num = 6'h15;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic [15:0] units;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [31:0] cyc_m = 0, bus_m = 0, hi_m = 0, lo_m = 800 << 19;

  always #5 clk = ~clk;

  sbus_ctrl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(we),
    .req_addr_i(addr), .req_len_i(len), .req_wdata_i(wdata),
    .cyc_cnt_i(cyc_cnt), .node_num_i(node_num),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .rsp_rdata_o(rsp_rdata), .split_units_o(units)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [3:0] l,
                     input logic [31:0] d, output logic [1:0] c, output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; len = l; wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(rsp_valid == 1'b1, "R1 valid", {31'd0, rsp_valid}, 32'd1);
    c = rsp_code; r = rsp_rdata;
    if (c != 2'b00 || w) chk(r == 32'd0, "R1 rdata zero", r, 32'd0);
  endtask

  function automatic logic [1:0] map_code(input logic [7:0] a, input logic w);
    case (a)
      8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20: return 2'b00;
      8'h08: return w ? 2'b00 : 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  // bench model of a time read (R7, R8, R9)
  task automatic time_rd(input logic [7:0] a, input logic [31:0] c, input string tag);
    logic [1:0] code; logic [31:0] r, e;
    cyc_cnt = c;
    if (c < cyc_m) bus_m = bus_m + 32'd128;
    cyc_m = c;
    e = (a == 8'h14) ? c : (bus_m | (c >> 25));
    acc(1'b0, a, 4'd4, 32'd0, code, r);
    chk(code == 2'b00 && r == e, tag, r, e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [1:0] code; logic [31:0] r, e;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 reset valid", {31'd0, rsp_valid}, 32'd0);
    chk(units == 16'd800, "R6 reset units", {16'd0, units}, 32'd800);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R10 R11: sweep of all aligned offsets, read
    for (int i = 0; i < 64; i++) begin
      logic [7:0] a = 8'(i * 4);
      acc(1'b0, a, 4'd4, 32'd0, code, r);
      chk(code == map_code(a, 1'b0), "R3 read code", {30'd0, code}, {30'd0, map_code(a, 1'b0)});
      if (code == 2'b00) begin
        case (a)
          8'h00: e = 32'd0;
          8'h04: e = {10'h3FF, 6'h15, 16'd0};
          8'h0C: e = 32'd0;
          8'h10: e = 32'd800 << 19;
          8'h20: e = 32'h8000_001F;
          default: e = 32'd0;
        endcase
        chk(r == e, "R3 R5 R10 R11 reset value", r, e);
      end
    end
    idle_check();

    // R2: misaligned addresses and bad lengths
    for (int b = 0; b < 9; b++) begin
      for (int o = 1; o < 4; o++) begin
        acc(1'b1, 8'(b * 4 + o), 4'd4, 32'hFFFF_FFFF, code, r);
        chk(code == 2'b01, "R2 misaligned addr", {30'd0, code}, 32'd1);
      end
    end
    for (int l = 0; l < 16; l++) begin
      if (l != 4) begin
        acc(1'b1, 8'h0C, 4'(l), 32'h7, code, r);
        chk(code == 2'b01, "R2 bad length", {30'd0, code}, 32'd1);
      end
    end
    chk(units == 16'd800, "R2 no state change", {16'd0, units}, 32'd800);

    // R4: state and reset-start
    acc(1'b1, 8'h00, 4'd4, 32'hFFFF_FFFF, code, r);
    chk(code == 2'b00, "R4 state write", {30'd0, code}, 32'd0);
    acc(1'b0, 8'h00, 4'd4, 32'd0, code, r);
    chk(r == 32'd0, "R4 state read", r, 32'd0);
    acc(1'b1, 8'h08, 4'd4, 32'hFFFF_FFFF, code, r);
    chk(code == 2'b00, "R4 reset-start write", {30'd0, code}, 32'd0);
    acc(1'b1, 8'h1C, 4'd4, 32'd0, code, r);
    chk(code == 2'b10, "R3 busy timeout write", {30'd0, code}, 32'd2);

    // R5 R6: sweep all high values with assorted low patterns
    for (int h = 0; h < 8; h++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] lw = 32'(k) * 32'h2B6D_4F1B ^ 32'h0007_FFFF;
        acc(1'b1, 8'h0C, 4'd4, {29'h1FFF_FFFF, 3'(h)}, code, r);
        acc(1'b1, 8'h10, 4'd4, lw, code, r);
        hi_m = 32'(h); lo_m = lw & 32'hFFF8_0000;
        e = (hi_m << 13) + (lo_m >> 19);
        chk({16'd0, units} == e, "R6 units", {16'd0, units}, e);
        acc(1'b0, 8'h0C, 4'd4, 32'd0, code, r);
        chk(r == hi_m, "R5 high mask", r, hi_m);
        acc(1'b0, 8'h10, 4'd4, 32'd0, code, r);
        chk(r == lo_m, "R5 low mask", r, lo_m);
      end
    end

    // R7 R8 R9: time sweep with wraps
    acc(1'b1, 8'h18, 4'd4, 32'hFFFF_FFFF, code, r);
    bus_m = 32'hFFFF_FF80;
    acc(1'b0, 8'h18, 4'd4, 32'd0, code, r);
    chk(r == 32'hFFFF_FF80, "R9 bus write mask", r, 32'hFFFF_FF80);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] c = 32'(i % 7) * 32'h2900_0000 + 32'(i) * 32'h135;
      time_rd((i % 2 == 0) ? 8'h18 : 8'h14, c, (i % 2 == 0) ? "R8 R9 bus read" : "R7 cycle read");
    end
    // R7: cycle write then wrap on next read
    acc(1'b1, 8'h14, 4'd4, 32'hF000_0000, code, r);
    cyc_m = 32'hF000_0000;
    time_rd(8'h18, 32'h0000_0001, "R8 wrap after cycle write");
    time_rd(8'h18, 32'h0000_0001, "R8 equal no wrap");
    acc(1'b1, 8'h18, 4'd4, 32'h1234_56FF, code, r);
    bus_m = 32'h1234_5680;
    time_rd(8'h14, 32'hFE00_0000, "R7 cycle sample");
    time_rd(8'h18, 32'hFE00_0000, "R9 bus merge");

    // R10: node IDs
    acc(1'b1, 8'h04, 4'd4, 32'h0000_FFFF, code, r);
    acc(1'b0, 8'h04, 4'd4, 32'd0, code, r);
    chk(r == 32'h0015_0000, "R10 bus field cleared", r, 32'h0015_0000);
    node_num = 6'h2A;
    acc(1'b1, 8'h04, 4'd4, 32'hABC0_0000, code, r);
    acc(1'b0, 8'h04, 4'd4, 32'd0, code, r);
    e = {10'(32'hABC0_0000 >> 22), 6'h2A, 16'd0};
    chk(r == e, "R10 bus field write", r, e);

    // R11: broadcast
    acc(1'b1, 8'h20, 4'd4, 32'hFFFF_FFFF, code, r);
    acc(1'b0, 8'h20, 4'd4, 32'd0, code, r);
    chk(r == 32'hC000_001F, "R11 valid set", r, 32'hC000_001F);
    acc(1'b1, 8'h20, 4'd4, 32'd0, code, r);
    acc(1'b0, 8'h20, 4'd4, 32'd0, code, r);
    chk(r == 32'h8000_001F, "R11 valid clear", r, 32'h8000_001F);

    idle_check();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic idle_check();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 idle no response", {31'd0, rsp_valid}, 32'd0);
  endtask
endmodule